// File: doc/BRIEF.md
# Host-Acknowledged Programmable Interrupt Generator

This block watches one byte of a small status register file and raises an active-low interrupt line when a host-programmed bit pattern shows up in that byte. The host chooses which register to watch, which bits of it matter (a mask), the polarity those bits must have, and whether any one of the chosen bits or all of them must match. The condition is only looked at on a rate tick. A control bit chooses between a fixed sample-rate tick (nominally 9600 Hz) and a data-rate tick. Both ticks arrive as one-cycle strobes from outside the block.

A sticky request flag works as a handshake with the host. The block sets the flag each time the condition is seen and never clears it itself. A new interrupt is raised only when the flag was clear just before, so at most one interrupt is outstanding until the host writes the flag back to zero. An interrupt-active status bit follows the interrupt line. The watched register file belongs to the surrounding design: the block presents a read address and takes back the byte through a combinational read port.

Top module: `prog_irq_gen`

## Requirements
- R1: While reset is applied, and after it, `irq_n` is 1 and `irq_active` and `req_flag` are 0.
- R2: A host write (`host_we` = 1) selects a field through `host_sel`. Code 0 is control: bit0 enable, bit1 rate select (1 = data tick), bit2 trigger polarity, bit3 combine mode (1 = AND). Code 1 is the mask. Code 2 is the watched address, which then appears on `rf_addr` one cycle later. Code 3 is a request write, where bit0 = 0 clears the request flag and bit0 = 1 does nothing.
- R3: In OR mode the condition holds when at least one masked bit of the watched byte equals the trigger polarity.
- R4: In AND mode the condition holds only when every masked bit of the watched byte equals the trigger polarity.
- R5: A mask of all zeros never produces the condition, in either mode.
- R6: With rate select 0 only `sample_tick` evaluates the condition. With rate select 1 only `data_tick` does. The tick that is not selected has no effect.
- R7: A condition that holds only in cycles without the selected tick is ignored.
- R8: On every selected tick where the condition holds, `req_flag` is 1 from the next cycle. It stays 1 until a host request-clear write.
- R9: When the condition holds on a tick and `req_flag` was 0, `irq_n` goes low and `irq_active` goes high in the next cycle. A request-clear write (with no tick carrying the condition) returns both to idle one cycle later.
- R10: A condition that holds again while `req_flag` is still 1 does not raise the interrupt.
- R11: With enable at 0, the condition never sets `req_flag` or the interrupt. Clearing enable drops `irq_n` high and `irq_active` low within two cycles of the write.
- R12: A request-clear write in the same cycle as a tick carrying the condition leaves `req_flag` at 1. The set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Field select for the host write |
| host_wdata | input | DATA_W | Host write data |
| sample_tick | input | 1 | Fixed sample-rate strobe |
| data_tick | input | 1 | Data-rate strobe |
| rf_addr | output | ADDR_W | Read address into the status register file |
| rf_data | input | DATA_W | Byte read back from the status register file |
| irq_n | output | 1 | Active-low interrupt to the host |
| irq_active | output | 1 | Interrupt-active status |
| req_flag | output | 1 | Sticky request flag |

## Verification
The pattern match is tried in several ways. Polarity 1 with a byte where only some masked bits are set passes OR but fails AND, which tells the two combine modes apart. Polarity 0 with a byte whose masked bits are all 1 fails, then one cleared bit passes, which shows the polarity is honoured. A zero mask with a byte that would otherwise match shows the mask gate. Each tick is also driven alone under each rate setting, and the condition is held steady between ticks, to show that only the selected strobe samples it. The handshake sequences cover a recurrence while the flag is set, a recurrence after the enable is toggled, and a clear that lands on the same cycle as a tick. These separate the sticky flag, the re-arm rule and the set-over-clear priority.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_REQ  = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic and_mode;   // bit3
    logic polarity;   // bit2
    logic rate_data;  // bit1
    logic enable;     // bit0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pirq_rst_sync.sv
module pirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              clr_req
);

  host_sel_e         sel;
  logic              ctrl_en, mask_en, addr_en;
  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] mask_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    sel     = host_sel_e'(host_sel);
    ctrl_en = host_we && (sel == SEL_CTRL);
    mask_en = host_we && (sel == SEL_MASK);
    addr_en = host_we && (sel == SEL_ADDR);
    ctrl_d  = ctrl_t'(host_wdata[CTRL_W-1:0]);
    mask_d  = host_wdata;
    addr_d  = host_wdata[ADDR_W-1:0];
    clr_req = host_we && (sel == SEL_REQ) && !host_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      addr_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (mask_en) mask_q <= mask_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 2'd2) |=> (addr_q == $past(host_wdata[ADDR_W-1:0]))); // R2

endmodule

// File: rtl/pirq_match.sv
module pirq_match #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mask,
  input  logic              polarity,
  input  logic              and_mode,
  input  logic [DATA_W-1:0] rf_data,
  output logic              hit
);

  logic [DATA_W-1:0] agree;
  logic [DATA_W-1:0] care_ok;
  logic              any_hit, all_hit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign agree[i]   = mask[i] & (rf_data[i] == polarity);
    assign care_ok[i] = ~mask[i] | (rf_data[i] == polarity);
  end

  assign any_hit = |agree;
  assign all_hit = (&care_ok) & (|mask);
  assign hit     = and_mode ? all_hit : any_hit;

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !hit); // R5

endmodule

// File: rtl/pirq_handshake.sv
module pirq_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cond,
  input  logic clr_req,
  output logic req_q,
  output logic active_q
);

  logic fire;
  logic req_d, req_upd;
  logic act_d, act_upd;

  always_comb begin
    fire    = cond & ~req_q;
    req_upd = cond | clr_req;
    req_d   = cond ? 1'b1 : 1'b0;
    act_upd = ~enable | fire | (clr_req & ~cond);
    if (!enable)   act_d = 1'b0;
    else if (fire) act_d = 1'b1;
    else           act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (req_upd) req_q    <= req_d;
      if (act_upd) active_q <= act_d;
    end
  end

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !clr_req) |=> req_q); // R8
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !active_q) |=> !active_q); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && clr_req) |=> req_q); // R12
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active_q); // R11

endmodule

// File: rtl/prog_irq_gen.sv
module prog_irq_gen
  import pirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              sample_tick,
  input  logic              data_tick,
  output logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  output logic              irq_n,
  output logic              irq_active,
  output logic              req_flag
);

  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] mask;
  logic              clr_req;
  logic              hit, tick_sel, cond;

  pirq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pirq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .ctrl_q     (ctrl),
    .mask_q     (mask),
    .addr_q     (rf_addr),
    .clr_req    (clr_req)
  );

  pirq_match #(.DATA_W(DATA_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mask     (mask),
    .polarity (ctrl.polarity),
    .and_mode (ctrl.and_mode),
    .rf_data  (rf_data),
    .hit      (hit)
  );

  assign tick_sel = ctrl.rate_data ? data_tick : sample_tick;
  assign cond     = ctrl.enable & tick_sel & hit;

  pirq_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enable   (ctrl.enable),
    .cond     (cond),
    .clr_req  (clr_req),
    .req_q    (req_flag),
    .active_q (irq_active)
  );

  assign irq_n = ~irq_active;

  AST_OFF_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick_sel |=> !$rose(req_flag)); // R7
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_n) |-> req_flag); // R9

endmodule

// File: tb/prog_irq_gen_test.sv
`timescale 1ns/1ps
module prog_irq_gen_test;
  import pirq_pkg::*;

  localparam int DW = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_we;
  logic [1:0]    host_sel;
  logic [DW-1:0] host_wdata;
  logic          sample_tick, data_tick;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_data;
  logic          irq_n, irq_active, req_flag;

  logic [DW-1:0] rf_mem [32];
  assign rf_data = rf_mem[rf_addr];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_en, m_rate, m_pol, m_and, m_req, m_act;
  bit [DW-1:0] m_mask;
  int          m_addr;

  prog_irq_gen #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .sample_tick(sample_tick), .data_tick(data_tick),
    .rf_addr(rf_addr), .rf_data(rf_data), .irq_n(irq_n),
    .irq_active(irq_active), .req_flag(req_flag)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    int masked, matched;
    bit tk, cnd, clr;
    if (!rst_n) begin
      m_en = 0; m_rate = 0; m_pol = 0; m_and = 0;
      m_req = 0; m_act = 0; m_mask = 0; m_addr = 0;
    end else begin
      masked = 0; matched = 0;
      for (int b = 0; b < DW; b++) begin
        if (m_mask[b]) begin
          masked++;
          if (rf_mem[m_addr][b] == m_pol) matched++;
        end
      end
      tk  = m_rate ? data_tick : sample_tick;
      cnd = m_en && tk && (m_and ? (masked > 0 && matched == masked) : (matched > 0));
      clr = host_we && host_sel == 2'd3 && !host_wdata[0];
      if (!m_en) m_act = 0;
      else if (cnd && !m_req) m_act = 1;
      else if (clr && !cnd) m_act = 0;
      if (cnd) m_req = 1;
      else if (clr) m_req = 0;
      if (host_we && host_sel == 2'd0) begin
        m_en = host_wdata[0]; m_rate = host_wdata[1];
        m_pol = host_wdata[2]; m_and = host_wdata[3];
      end
      if (host_we && host_sel == 2'd1) m_mask = host_wdata;
      if (host_we && host_sel == 2'd2) m_addr = int'(host_wdata[AW-1:0]);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R9 model irq_n", int'(irq_n), int'(!m_act));
    chk("R9 model irq_active", int'(irq_active), int'(m_act));
    chk("R8 model req_flag", int'(req_flag), int'(m_req));
    chk("R2 model rf_addr", int'(rf_addr), m_addr);
  endtask

  task automatic hwrite(input logic [1:0] s, input logic [DW-1:0] d);
    host_we = 1; host_sel = s; host_wdata = d;
    step();
    host_we = 0;
  endtask

  task automatic stick();
    sample_tick = 1; step(); sample_tick = 0;
  endtask

  task automatic dtick();
    data_tick = 1; step(); data_tick = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual %0d expected below %0d cycles", 20000, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) rf_mem[i] = '0;
    rst_n = 0; host_we = 0; host_sel = 0; host_wdata = 0;
    sample_tick = 0; data_tick = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq_n in reset", int'(irq_n), 1);
    chk("R1 active in reset", int'(irq_active), 0);
    chk("R1 req in reset", int'(req_flag), 0);
    rst_n = 1;
    repeat (4) step();
    chk("R1 irq_n after reset", int'(irq_n), 1);

    // OR mode, polarity 1, sample rate
    rf_mem[5] = 8'hA0;
    hwrite(2'd2, 8'h05);
    chk("R2 rf_addr", int'(rf_addr), 5);
    hwrite(2'd1, 8'hF0);
    hwrite(2'd0, 8'h05);
    dtick();
    chk("R6 data tick ignored at sample rate", int'(irq_n), 1);
    chk("R6 req untouched", int'(req_flag), 0);
    stick();
    chk("R3 OR hit irq_n", int'(irq_n), 0);
    chk("R9 active set", int'(irq_active), 1);
    chk("R8 req set", int'(req_flag), 1);
    stick();
    chk("R9 irq held", int'(irq_n), 0);
    hwrite(2'd3, 8'h01);
    chk("R2 request write of 1 ignored", int'(req_flag), 1);
    hwrite(2'd3, 8'h00);
    chk("R9 clear irq_n", int'(irq_n), 1);
    chk("R9 clear active", int'(irq_active), 0);
    chk("R8 clear req", int'(req_flag), 0);

    // AND mode
    hwrite(2'd0, 8'h0D);
    stick();
    chk("R4 AND partial no irq", int'(irq_n), 1);
    chk("R4 AND partial no req", int'(req_flag), 0);
    rf_mem[5] = 8'hF3;
    stick();
    chk("R4 AND full irq", int'(irq_n), 0);
    hwrite(2'd3, 8'h00);

    // OR mode, polarity 0
    hwrite(2'd0, 8'h01);
    hwrite(2'd1, 8'h0F);
    rf_mem[5] = 8'h0F;
    stick();
    chk("R3 pol0 no zero bit", int'(irq_n), 1);
    rf_mem[5] = 8'h0E;
    stick();
    chk("R3 pol0 one zero bit", int'(irq_n), 0);
    hwrite(2'd3, 8'h00);

    // zero mask
    hwrite(2'd1, 8'h00);
    rf_mem[5] = 8'h00;
    stick();
    chk("R5 zero mask OR", int'(req_flag), 0);
    hwrite(2'd0, 8'h09);
    stick();
    chk("R5 zero mask AND", int'(req_flag), 0);
    chk("R5 zero mask irq", int'(irq_n), 1);

    // data rate
    hwrite(2'd1, 8'hFF);
    hwrite(2'd0, 8'h03);
    stick();
    chk("R6 sample tick ignored at data rate", int'(irq_n), 1);
    repeat (5) step();
    chk("R7 no tick no irq", int'(irq_n), 1);
    chk("R7 no tick no req", int'(req_flag), 0);
    dtick();
    chk("R6 data tick fires", int'(irq_n), 0);

    // recurrence while request set
    hwrite(2'd0, 8'h02);
    step();
    chk("R11 disable drops irq", int'(irq_n), 1);
    chk("R8 req kept after disable", int'(req_flag), 1);
    hwrite(2'd0, 8'h03);
    dtick();
    chk("R10 no rearm while req set", int'(irq_n), 1);
    chk("R10 req still set", int'(req_flag), 1);
    hwrite(2'd3, 8'h00);
    dtick();
    chk("R10 rearm after clear", int'(irq_n), 0);

    // clear and tick in the same cycle
    host_we = 1; host_sel = 2'd3; host_wdata = 8'h00; data_tick = 1;
    step();
    host_we = 0; data_tick = 0;
    chk("R12 set wins req", int'(req_flag), 1);
    chk("R12 set wins irq", int'(irq_n), 0);
    hwrite(2'd3, 8'h00);
    chk("R9 cleared", int'(req_flag), 0);
    host_we = 1; host_sel = 2'd3; host_wdata = 8'h00; data_tick = 1;
    step();
    host_we = 0; data_tick = 0;
    chk("R12 set wins from clear state", int'(req_flag), 1);
    chk("R12 fires from clear state", int'(irq_n), 0);

    // enable off
    hwrite(2'd3, 8'h00);
    hwrite(2'd0, 8'h02);
    dtick();
    chk("R11 disabled no req", int'(req_flag), 0);
    chk("R11 disabled no irq", int'(irq_n), 1);
    chk("R11 disabled no active", int'(irq_active), 0);

    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule